// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register-facing half of a memory-mapped serial port. A host reaches it through a plain 32-bit word bus: address, read strobe, write strobe, write data and a combinational read-data return. Received bytes arrive on a byte stream and are queued in an internal receive FIFO. The block reports the free space in that FIFO back to the sender. Bytes the host writes are handed to a one-entry transmit holding stage, which drives a valid/ready byte stream toward the line logic.

A companion DMA engine moves the bulk data. This block only keeps the two DMA address registers and issues a start pulse with a count. It also reads back the engine's remaining receive count. While that count is nonzero, received bytes belong to the DMA engine and are not queued here.

A single level interrupt combines three status conditions through a 3-bit enable mask:
- bit 0: the FIFO holds data;
- bit 1: transmit DMA done, which is always true;
- bit 2: the receive DMA has nothing left to do.

Top module: `serial_reg_front`

## Requirements
- R1: The register at word index 0 (byte address 0x00) always reads 0xC51D0001. Word index 5 (transmit count) reads 0. Any word index of 8 or more reads 0. The word index is the byte address shifted right by two.
- R2: A read of word index 1 pops the oldest queued byte and returns it zero-extended to 32 bits, in arrival order.
- R3: A read of word index 1 with an empty FIFO returns 0xFFFFFFFF and leaves the FIFO count at 0.
- R4: A read of word index 2 returns the number of queued bytes. `rx_space` equals FIFO_DEPTH (default 16) minus that number.
- R5: A byte that arrives with the FIFO full, and no receive DMA active, is discarded. The FIFO contents and order are unchanged, and the sticky `rx_overflow` output goes high and stays high.
- R6: While `dma_rx_remain` is nonzero, received bytes are not queued, so the FIFO count does not change.
- R7: A write to word index 3 stores bits [2:0] of the write data as the interrupt enable mask, and a read returns that mask zero-extended.
- R8: `irq` is high exactly when (status AND mask) is nonzero. Status is {dma_rx_remain==0, 1, FIFO not empty} in bits [2:0]. `irq` follows any change within the same cycle in which the state changes.
- R9: A write to word index 1 presents write-data bits [7:0] on `tx_data` with `tx_valid` high from the next cycle. The byte is held until `tx_ready` is seen. A write while a byte is still pending and not being accepted is discarded.
- R10: Word indexes 4 and 6 are 32-bit read/write address registers that drive `dma_tx_addr` and `dma_rx_addr`. Word index 7 reads `dma_rx_remain`.
- R11: A write to word index 5 (or 7) raises `dma_tx_go` (or `dma_rx_go`) for exactly one cycle, the cycle after the write, with the write data on `dma_count`.
- R12: Writes to word indexes 0 and 2, and to word indexes of 8 or more, change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_space | output | clog2(FIFO_DEPTH+1) | Free FIFO entries |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Line logic accepts the transmit byte |
| dma_rx_remain | input | 32 | Remaining receive DMA count from the engine |
| dma_tx_addr | output | 32 | Transmit DMA address register |
| dma_rx_addr | output | 32 | Receive DMA address register |
| dma_tx_go | output | 1 | One-cycle transmit DMA start |
| dma_rx_go | output | 1 | One-cycle receive DMA start |
| dma_count | output | 32 | Count that goes with a start pulse |
| irq | output | 1 | Level interrupt |
| rx_overflow | output | 1 | Sticky flag: a byte was dropped on a full FIFO |

## Verification
The receive path is driven with several byte patterns. A plain ascending run shows FIFO order. A 0x00 byte and a 0xFF byte separate real data from the all-ones empty marker. A run of depth-plus-one bytes shows the drop on overflow, and confirms that the dropped byte is the newest one rather than an older entry.

Received bytes sent while the DMA remaining count is nonzero separate the bypass from queueing. The interrupt mask is stepped through each single bit against matching and non-matching status, which shows each source is gated on its own. The transmit stage is held off with `tx_ready` low while a second write arrives, which tells a held byte from one that was overwritten.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam logic [31:0] SFR_ID_VALUE = 32'hC51D_0001;

  typedef enum logic [2:0] {
    OFS_ID   = 3'd0,
    OFS_DATA = 3'd1,
    OFS_CNT  = 3'd2,
    OFS_IEN  = 3'd3,
    OFS_TXA  = 3'd4,
    OFS_TXN  = 3'd5,
    OFS_RXA  = 3'd6,
    OFS_RXN  = 3'd7
  } reg_ofs_e;

  // status vector: [2] rx dma idle, [1] tx dma done (constant), [0] fifo has data
  function automatic logic [2:0] int_status(input logic has_data, input logic rx_idle);
    return {rx_idle, 1'b1, has_data};
  endfunction

  function automatic logic irq_level(input logic [2:0] st, input logic [2:0] en);
    return |(st & en);
  endfunction

endpackage

// File: rtl/sfr_rx_fifo.sv
module sfr_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] space,
  output logic          empty,
  output logic          full
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign space   = CW'(DEPTH) - count;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/sfr_tx_hold.sv
module sfr_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data
);

  logic slot_free;
  assign slot_free = !tx_valid || tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load && slot_free) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
  import sfr_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 12,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic [CW-1:0]     rx_space,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic [31:0]       dma_rx_remain,
  output logic [31:0]       dma_tx_addr,
  output logic [31:0]       dma_rx_addr,
  output logic              dma_tx_go,
  output logic              dma_rx_go,
  output logic [31:0]       dma_count,
  output logic              irq,
  output logic              rx_overflow
);

  // ---------------- decode ----------------
  logic [ADDR_W-1:0] word_idx;
  logic              mapped;
  reg_ofs_e          ofs;

  assign word_idx = bus_addr >> 2;
  assign mapped   = (word_idx < ADDR_W'(8));
  assign ofs      = reg_ofs_e'(word_idx[2:0]);

  logic wr_data, wr_ien, wr_txa, wr_txn, wr_rxa, wr_rxn, rd_data;
  assign wr_data = bus_wr && mapped && (ofs == OFS_DATA);
  assign wr_ien  = bus_wr && mapped && (ofs == OFS_IEN);
  assign wr_txa  = bus_wr && mapped && (ofs == OFS_TXA);
  assign wr_txn  = bus_wr && mapped && (ofs == OFS_TXN);
  assign wr_rxa  = bus_wr && mapped && (ofs == OFS_RXA);
  assign wr_rxn  = bus_wr && mapped && (ofs == OFS_RXN);
  assign rd_data = bus_rd && mapped && (ofs == OFS_DATA);

  // ---------------- receive path ----------------
  logic          rx_idle;
  logic          fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [7:0]    fifo_head;
  logic [CW-1:0] fifo_count;
  logic          drop_evt;

  assign rx_idle   = (dma_rx_remain == 32'd0);
  assign fifo_push = rx_valid && rx_idle;
  assign fifo_pop  = rd_data && !fifo_empty;
  assign drop_evt  = fifo_push && fifo_full;

  sfr_rx_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fifo_push),
    .push_data (rx_data),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .count     (fifo_count),
    .space     (rx_space),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  // ---------------- transmit path ----------------
  sfr_tx_hold #(.DW(8)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_data),
    .load_data (bus_wdata[7:0]),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data)
  );

  // ---------------- control registers ----------------
  logic [2:0] int_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en      <= '0;
      dma_tx_addr <= '0;
      dma_rx_addr <= '0;
      dma_tx_go   <= 1'b0;
      dma_rx_go   <= 1'b0;
      dma_count   <= '0;
      rx_overflow <= 1'b0;
    end else begin
      dma_tx_go <= wr_txn;
      dma_rx_go <= wr_rxn;
      if (wr_ien)          int_en      <= bus_wdata[2:0];
      if (wr_txa)          dma_tx_addr <= bus_wdata;
      if (wr_rxa)          dma_rx_addr <= bus_wdata;
      if (wr_txn || wr_rxn) dma_count  <= bus_wdata;
      if (drop_evt)        rx_overflow <= 1'b1;
    end
  end

  // ---------------- interrupt ----------------
  assign irq = irq_level(int_status(!fifo_empty, rx_idle), int_en);

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (mapped) begin
      case (ofs)
        OFS_ID:   bus_rdata = SFR_ID_VALUE;
        OFS_DATA: bus_rdata = fifo_empty ? 32'hFFFF_FFFF : {24'd0, fifo_head};
        OFS_CNT:  bus_rdata = 32'(fifo_count);
        OFS_IEN:  bus_rdata = {29'd0, int_en};
        OFS_TXA:  bus_rdata = dma_tx_addr;
        OFS_TXN:  bus_rdata = '0;
        OFS_RXA:  bus_rdata = dma_rx_addr;
        OFS_RXN:  bus_rdata = dma_rx_remain;
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 12,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] word_idx,
  input logic [31:0]       bus_rdata,
  input logic [CW-1:0]     fifo_count,
  input logic              fifo_pop,
  input logic              rx_valid,
  input logic [31:0]       dma_rx_remain,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              dma_tx_go,
  input logic              dma_rx_go,
  input logic [2:0]        int_en,
  input logic              irq,
  input logic              rx_overflow
);

  a_r3_empty_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && word_idx == ADDR_W'(1) && fifo_count == '0) |-> bus_rdata == 32'hFFFF_FFFF);

  a_r5_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> rx_overflow);

  a_r6_bypass_no_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && dma_rx_remain != 32'd0 && !fifo_pop) |=> $stable(fifo_count));

  a_r8_tx_source_always: assert property (@(posedge clk) disable iff (!rst_n)
    int_en[1] |-> irq);

  a_r9_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r11_single_go: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_tx_go, dma_rx_go}));

endmodule

bind serial_reg_front sfr_checker #(.DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_rd        (bus_rd),
  .word_idx      (word_idx),
  .bus_rdata     (bus_rdata),
  .fifo_count    (fifo_count),
  .fifo_pop      (fifo_pop),
  .rx_valid      (rx_valid),
  .dma_rx_remain (dma_rx_remain),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_data       (tx_data),
  .dma_tx_go     (dma_tx_go),
  .dma_rx_go     (dma_rx_go),
  .int_en        (int_en),
  .irq           (irq),
  .rx_overflow   (rx_overflow)
);

// File: tb/tb_serial_reg_front.sv
`timescale 1ns/1ps
module tb_serial_reg_front;

  localparam int DEPTH  = 16;
  localparam int ADDR_W = 12;
  localparam int CW     = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              rx_valid = 1'b0;
  logic [7:0]        rx_data = '0;
  logic [CW-1:0]     rx_space;
  logic              tx_valid, tx_ready = 1'b0;
  logic [7:0]        tx_data;
  logic [31:0]       dma_rx_remain = '0;
  logic [31:0]       dma_tx_addr, dma_rx_addr, dma_count;
  logic              dma_tx_go, dma_rx_go, irq, rx_overflow;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  serial_reg_front #(.FIFO_DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_space(rx_space), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .dma_rx_remain(dma_rx_remain), .dma_tx_addr(dma_tx_addr), .dma_rx_addr(dma_rx_addr),
    .dma_tx_go(dma_tx_go), .dma_rx_go(dma_rx_go), .dma_count(dma_count), .irq(irq),
    .rx_overflow(rx_overflow)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int widx, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = ADDR_W'(widx * 4);
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input int widx, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(widx * 4);
    bus_rd   = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R4 reset rx_space", 32'(rx_space), 32'(DEPTH));
    check("R8 reset irq", 32'(irq), 32'd0);
    check("R9 reset tx_valid", 32'(tx_valid), 32'd0);
    check("R5 reset overflow", 32'(rx_overflow), 32'd0);
    bus_read(2, v);
    check("R4 reset count", v, 32'd0);
  endtask

  task automatic t_id_map;
    logic [31:0] v;
    bus_read(0, v);  check("R1 id", v, 32'hC51D_0001);
    bus_read(5, v);  check("R1 tx count reads 0", v, 32'd0);
    bus_read(8, v);  check("R1 unmapped 8", v, 32'd0);
    bus_read(1000, v); check("R1 unmapped high", v, 32'd0);
    bus_write(0, 32'h1234_5678);
    bus_read(0, v);  check("R12 id write ignored", v, 32'hC51D_0001);
    bus_write(2, 32'd5);
    bus_read(2, v);  check("R12 count write ignored", v, 32'd0);
    bus_write(9, 32'hFFFF_FFFF);
    bus_read(3, v);  check("R12 unmapped write leaves mask", v, 32'd0);
    bus_read(4, v);  check("R12 unmapped write leaves txa", v, 32'd0);
  endtask

  task automatic t_empty_read;
    logic [31:0] v;
    bus_read(1, v); check("R3 empty read ones", v, 32'hFFFF_FFFF);
    bus_read(2, v); check("R3 empty read no pop", v, 32'd0);
  endtask

  task automatic t_order;
    logic [31:0] v;
    rx_send(8'h41); rx_send(8'h00); rx_send(8'hFF);
    bus_read(2, v); check("R4 count 3", v, 32'd3);
    check("R4 space 13", 32'(rx_space), 32'(DEPTH - 3));
    bus_read(1, v); check("R2 first", v, 32'h41);
    bus_read(1, v); check("R2 zero byte", v, 32'h00);
    bus_read(1, v); check("R2 ff zero-extended", v, 32'h0000_00FF);
    bus_read(2, v); check("R2 drained", v, 32'd0);
  endtask

  task automatic t_full;
    logic [31:0] v;
    for (int i = 0; i < DEPTH; i++) rx_send(8'(8'h10 + i));
    check("R4 space 0", 32'(rx_space), 32'd0);
    check("R5 no overflow yet", 32'(rx_overflow), 32'd0);
    rx_send(8'hEE);
    check("R5 overflow set", 32'(rx_overflow), 32'd1);
    bus_read(2, v); check("R5 count stays full", v, 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(1, v);
      check("R5 order after drop", v, 32'(8'h10 + i));
    end
    bus_read(1, v); check("R5 dropped byte absent", v, 32'hFFFF_FFFF);
    check("R5 overflow sticky", 32'(rx_overflow), 32'd1);
  endtask

  task automatic t_bypass;
    logic [31:0] v;
    @(negedge clk); dma_rx_remain = 32'd3;
    rx_send(8'h55); rx_send(8'h66);
    bus_read(2, v); check("R6 bypass count 0", v, 32'd0);
    bus_read(7, v); check("R10 rx remain readback", v, 32'd3);
    @(negedge clk); dma_rx_remain = 32'd0;
    rx_send(8'h77);
    bus_read(2, v); check("R6 queued when idle", v, 32'd1);
    bus_read(1, v); check("R6 byte queued", v, 32'h77);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    bus_write(3, 32'hFFFF_FFF8);
    bus_read(3, v); check("R7 mask low bits only", v, 32'd0);
    bus_write(3, 32'hFFFF_FFFF);
    bus_read(3, v); check("R7 mask readback", v, 32'd7);
    bus_write(3, 32'd1);
    check("R8 data source empty", 32'(irq), 32'd0);
    rx_send(8'h12);
    check("R8 data source set", 32'(irq), 32'd1);
    bus_read(1, v);
    check("R8 data source cleared", 32'(irq), 32'd0);
    bus_write(3, 32'd2);
    check("R8 tx source always", 32'(irq), 32'd1);
    bus_write(3, 32'd4);
    check("R8 rx idle source", 32'(irq), 32'd1);
    @(negedge clk); dma_rx_remain = 32'd5;
    #1 check("R8 rx busy source", 32'(irq), 32'd0);
    @(negedge clk); dma_rx_remain = 32'd0;
    bus_write(3, 32'd0);
    check("R8 masked off", 32'(irq), 32'd0);
  endtask

  task automatic t_tx;
    bus_write(1, 32'h1234_56AB);
    check("R9 tx valid", 32'(tx_valid), 32'd1);
    check("R9 tx low byte", 32'(tx_data), 32'hAB);
    bus_write(1, 32'h0000_00CD);
    check("R9 pending byte kept", 32'(tx_data), 32'hAB);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    check("R9 second write dropped", 32'(tx_valid), 32'd0);
    bus_write(1, 32'h0000_005A);
    check("R9 new byte", 32'(tx_data), 32'h5A);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic t_dma;
    logic [31:0] v;
    bus_write(4, 32'h8000_0010);
    bus_read(4, v); check("R10 txa readback", v, 32'h8000_0010);
    check("R10 txa output", dma_tx_addr, 32'h8000_0010);
    bus_write(6, 32'h0000_4400);
    bus_read(6, v); check("R10 rxa readback", v, 32'h0000_4400);
    check("R10 rxa output", dma_rx_addr, 32'h0000_4400);
    check("R11 idle go", 32'({dma_tx_go, dma_rx_go}), 32'd0);
    bus_write(5, 32'd9);
    check("R11 tx go pulse", 32'({dma_tx_go, dma_rx_go}), 32'b10);
    check("R11 tx count", dma_count, 32'd9);
    @(negedge clk);
    check("R11 tx go one cycle", 32'(dma_tx_go), 32'd0);
    bus_write(7, 32'd4);
    check("R11 rx go pulse", 32'({dma_tx_go, dma_rx_go}), 32'b01);
    check("R11 rx count", dma_count, 32'd4);
    @(negedge clk);
    check("R11 rx go one cycle", 32'(dma_rx_go), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_id_map();
    t_empty_read();
    t_order();
    t_full();
    t_bypass();
    t_irq();
    t_tx();
    t_dma();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule